// File: doc/BRIEF.md
# Profile-Selected RAM Segment Sequencer

This block replays a stretch of a 1024-entry table of 32-bit words, such as a list of frequency tuning words, onto a single output bus. The table is split into segments by software. Each segment is described by a 40-bit control word that gives the entry where it starts and the entry where it ends. The control word also sets how long each entry is held, an operating-mode code, and a flag that chooses what the output shows once the sweep is over.

Control words are first written into a staging bank, one per profile, and are copied into the live bank only when the update strobe is pulsed. Whenever the profile-select input changes value, the sequencer loads the live control word of the newly selected profile and walks the read address upward through the segment. The address moves at most once per sync tick, which is one quarter of the system clock rate by default. Only the ramp-up code is played. Any other code is reported as unsupported, and the output is left alone.

Top module: `ramp_segment_player`

## Requirements
- R1: After reset, busy, done and bad_mode are 0, word_out equals the parameter IDLE_WORD, and every live control word is all zeros.
- R2: A control word written through cw_wr_en/cw_wr_idx/cw_wr_data has no effect on playback until cw_update is pulsed. Until then the profile plays its previous live word, which is all zeros after reset (mode 0, so bad_mode is raised).
- R3: The 40-bit control word is laid out as hold rate in [39:24], last address in [23:14], first address in [13:4], mode code in [3:1] and the hold-last flag inverse (no-dwell) in [0].
- R4: In ramp-up mode (code 3'b001), word_out shows table[first], table[first+1] and so on up to table[last], in ascending order. Each entry is held for (rate+1) sync ticks, and one sync tick is SYNC_DIV = 4 clock cycles. Rate 0 therefore advances one entry every sync tick.
- R5: busy is 1 from the first clock edge after the profile change until the hold time of the last entry expires. The number of cycles busy is high lies between 4*N*(rate+1)-3 and 4*N*(rate+1), where N is the number of entries. done is high for exactly one cycle, the first cycle in which busy is 0 again.
- R6: After the sweep, word_out keeps showing table[last] when the no-dwell bit is 0, and shows IDLE_WORD when the bit is 1.
- R7: If the first address is greater than the last address, the segment is the single entry at the first address.
- R8: A mode code other than 3'b001 sets bad_mode, starts no sweep and leaves word_out unchanged. bad_mode clears at the next start that carries the ramp-up code.
- R9: Any change of prof_sel (a 0-to-1 change of bit 0, such as 00 to 01, or any other change) starts the sweep of the newly selected profile's control word. A change during a sweep abandons the running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cw_wr_en | input | 1 | Write strobe for the staging control-word bank |
| cw_wr_idx | input | 2 | Profile whose staging word is written |
| cw_wr_data | input | 40 | Control word value (layout in R3) |
| cw_update | input | 1 | Copies all staging words into the live bank |
| ram_we | input | 1 | Table write strobe |
| ram_waddr | input | 10 | Table write address |
| ram_wdata | input | 32 | Table write data |
| prof_sel | input | 2 | Profile select; a change starts a sweep |
| word_out | output | 32 | Current table word or IDLE_WORD |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when a sweep finishes |
| bad_mode | output | 1 | Last start carried an unsupported mode code |

## Verification
The hardest situation to reach from the ports is the unknown phase of the free-running sync tick at the moment the profile changes. It means the first entry can be held for up to three cycles less than the others. The bench does not predict the phase. It checks the sequence of distinct words shown while busy, and it checks busy duration against the bounded window of R5. Random segments that sit near the top of the table, with random rates and no-dwell settings, are mixed with directed cases for a reversed address pair, a staged write without an update, and an unsupported mode code.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   localparam int ADDR_W  = 10;
   localparam int RATE_W  = 16;
   localparam int MODE_W  = 3;
   localparam int CW_W    = RATE_W + 2*ADDR_W + MODE_W + 1;

   localparam logic [MODE_W-1:0] MODE_RAMP_UP = 3'b001;

   typedef struct packed {
      logic [RATE_W-1:0] rate;
      logic [ADDR_W-1:0] last;
      logic [ADDR_W-1:0] first;
      logic [MODE_W-1:0] mode;
      logic              no_dwell;
   } seg_cw_t;
endpackage

// File: rtl/rsp_cw_bank.sv
module rsp_cw_bank
   import rsp_pkg::*;
#(
   parameter int NUM_PROF = 4,
   localparam int PS_W    = $clog2(NUM_PROF)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [PS_W-1:0] wr_idx,
   input  logic [CW_W-1:0] wr_data,
   input  logic            update,
   input  logic [PS_W-1:0] rd_idx,
   output seg_cw_t         rd_cw
);
   seg_cw_t staged [NUM_PROF];
   seg_cw_t live   [NUM_PROF];

   for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            staged[p] <= '0;
            live[p]   <= '0;
         end else begin
            if (wr_en && wr_idx == PS_W'(p)) staged[p] <= seg_cw_t'(wr_data);
            if (update) live[p] <= staged[p];
         end
      end
   end

   assign rd_cw = live[rd_idx];
endmodule

// File: rtl/rsp_sync_tick.sv
module rsp_sync_tick #(
   parameter int DIV = 4,
   localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV == 1) begin : g_direct
      assign tick = 1'b1;
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         cnt <= '0;
         else if (cnt == CNT_W'(DIV - 1))    cnt <= '0;
         else                                cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CNT_W'(DIV - 1));
   end
endmodule

// File: rtl/rsp_walker.sv
module rsp_walker
   import rsp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  seg_cw_t           cw,
   input  logic              tick,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] seg_beg,
   output logic [ADDR_W-1:0] seg_end,
   output logic              busy,
   output logic              done,
   output logic              show_idle,
   output logic              bad_mode
);
   logic [RATE_W-1:0] rate_q;
   logic [RATE_W-1:0] wait_cnt;
   logic              nd_q;
   logic              is_ramp;

   assign is_ramp = (cw.mode == MODE_RAMP_UP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr      <= '0;
         seg_beg   <= '0;
         seg_end   <= '0;
         rate_q    <= '0;
         wait_cnt  <= '0;
         nd_q      <= 1'b0;
         busy      <= 1'b0;
         done      <= 1'b0;
         show_idle <= 1'b1;
         bad_mode  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            bad_mode <= !is_ramp;
            busy     <= is_ramp;
            if (is_ramp) begin
               addr      <= cw.first;
               seg_beg   <= cw.first;
               seg_end   <= (cw.first > cw.last) ? cw.first : cw.last;
               rate_q    <= cw.rate;
               nd_q      <= cw.no_dwell;
               wait_cnt  <= '0;
               show_idle <= 1'b0;
            end
         end else if (busy && tick) begin
            if (wait_cnt == rate_q) begin
               wait_cnt <= '0;
               if (addr == seg_end) begin
                  busy      <= 1'b0;
                  done      <= 1'b1;
                  show_idle <= nd_q;
               end else begin
                  addr <= addr + 1'b1;
               end
            end else begin
               wait_cnt <= wait_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rsp_word_ram.sv
module rsp_word_ram #(
   parameter int AW = 10,
   parameter int DW = 32,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/ramp_segment_player.sv
module ramp_segment_player
   import rsp_pkg::*;
#(
   parameter int          TABLE_AW  = 10,
   parameter int          DATA_W    = 32,
   parameter int          NUM_PROF  = 4,
   parameter int          SYNC_DIV  = 4,
   parameter logic [31:0] IDLE_WORD = 32'hA5A5_5A5A,
   localparam int         PS_W      = $clog2(NUM_PROF)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cw_wr_en,
   input  logic [PS_W-1:0]     cw_wr_idx,
   input  logic [CW_W-1:0]     cw_wr_data,
   input  logic                cw_update,
   input  logic                ram_we,
   input  logic [TABLE_AW-1:0] ram_waddr,
   input  logic [DATA_W-1:0]   ram_wdata,
   input  logic [PS_W-1:0]     prof_sel,
   output logic [DATA_W-1:0]   word_out,
   output logic                busy,
   output logic                done,
   output logic                bad_mode
);
   if (TABLE_AW != ADDR_W) begin : g_bad_aw
      $error("TABLE_AW must match the control-word address field width");
   end
   if (NUM_PROF < 2 || (1 << PS_W) != NUM_PROF) begin : g_bad_prof
      $error("NUM_PROF must be a power of two of at least 2");
   end
   if (SYNC_DIV < 1) begin : g_bad_div
      $error("SYNC_DIV must be at least 1");
   end
   if (DATA_W > 32) begin : g_bad_dw
      $error("DATA_W is limited by IDLE_WORD to 32 bits");
   end

   logic [PS_W-1:0]     ps_q;
   logic                start;
   logic                tick;
   logic                show_idle;
   seg_cw_t             sel_cw;
   logic [ADDR_W-1:0]   rd_addr;
   logic [ADDR_W-1:0]   seg_beg;
   logic [ADDR_W-1:0]   seg_end;
   logic [DATA_W-1:0]   rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ps_q <= '0;
      else        ps_q <= prof_sel;
   end
   assign start = (prof_sel != ps_q);

   rsp_cw_bank #(.NUM_PROF(NUM_PROF)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cw_wr_en), .wr_idx(cw_wr_idx),
      .wr_data(cw_wr_data), .update(cw_update), .rd_idx(prof_sel), .rd_cw(sel_cw)
   );

   rsp_sync_tick #(.DIV(SYNC_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   rsp_walker u_walk (
      .clk(clk), .rst_n(rst_n), .start(start), .cw(sel_cw), .tick(tick),
      .addr(rd_addr), .seg_beg(seg_beg), .seg_end(seg_end), .busy(busy),
      .done(done), .show_idle(show_idle), .bad_mode(bad_mode)
   );

   rsp_word_ram #(.AW(TABLE_AW), .DW(DATA_W)) u_ram (
      .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
      .raddr(rd_addr), .rdata(rd_word)
   );

   assign word_out = show_idle ? IDLE_WORD[DATA_W-1:0] : rd_word;
endmodule

// File: rtl/rsp_checks.sv
module rsp_checks
   import rsp_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              bad_mode,
   input logic              start,
   input logic [MODE_W-1:0] start_mode,
   input logic [ADDR_W-1:0] addr,
   input logic [ADDR_W-1:0] seg_beg,
   input logic [ADDR_W-1:0] seg_end
);
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_BAD_NO_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      bad_mode |-> !busy); // R8
   AST_ADDR_IN_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (addr >= seg_beg && addr <= seg_end)); // R4
   AST_ADDR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(start)) |->
         (addr == $past(addr) || addr == $past(addr) + 1'b1)); // R4
   AST_START_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && start_mode == MODE_RAMP_UP) |=> (busy && !bad_mode)); // R9
   AST_START_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (start && start_mode != MODE_RAMP_UP) |=> (bad_mode && !busy)); // R8
endmodule

bind ramp_segment_player rsp_checks u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bad_mode(bad_mode),
   .start(start), .start_mode(sel_cw.mode), .addr(rd_addr),
   .seg_beg(seg_beg), .seg_end(seg_end)
);

// File: tb/tb_ramp_segment_player.sv
`timescale 1ns/1ps
module tb_ramp_segment_player;
   localparam logic [31:0] IDLE = 32'hA5A5_5A5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cw_wr_en = 1'b0;
   logic [1:0]  cw_wr_idx = '0;
   logic [39:0] cw_wr_data = '0;
   logic        cw_update = 1'b0;
   logic        ram_we = 1'b0;
   logic [9:0]  ram_waddr = '0;
   logic [31:0] ram_wdata = '0;
   logic [1:0]  prof_sel = '0;
   logic [31:0] word_out;
   logic        busy, done, bad_mode;

   int n_total = 0;
   int n_bad   = 0;

   always #5 clk = ~clk;

   ramp_segment_player #(.IDLE_WORD(IDLE)) dut (
      .clk(clk), .rst_n(rst_n), .cw_wr_en(cw_wr_en), .cw_wr_idx(cw_wr_idx),
      .cw_wr_data(cw_wr_data), .cw_update(cw_update), .ram_we(ram_we),
      .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .prof_sel(prof_sel),
      .word_out(word_out), .busy(busy), .done(done), .bad_mode(bad_mode)
   );

   function automatic logic [31:0] tab_val(input int a);
      return 32'(a) * 32'h9E37_79B1 + 32'h1357_2468;
   endfunction

   // R3 layout
   function automatic logic [39:0] pack_cw(input int rate, input int last, input int first,
                                           input int mode, input bit nd);
      return {16'(rate), 10'(last), 10'(first), 3'(mode), nd};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_cw(input int idx, input logic [39:0] w, input bit upd);
      @(negedge clk);
      cw_wr_en = 1'b1; cw_wr_idx = 2'(idx); cw_wr_data = w;
      @(negedge clk);
      cw_wr_en = 1'b0;
      if (upd) begin
         cw_update = 1'b1;
         @(negedge clk);
         cw_update = 1'b0;
      end
   endtask

   // Change profile and follow the sweep; checks R4 R5 R6 R7 R9
   task automatic sweep(input int ps, input int first, input int last, input int rate, input bit nd);
      int fin, cnt, idx, nb, lo, hi;
      logic [31:0] prev;
      bit bad_seq;
      fin = (first > last) ? first : last;
      cnt = fin - first + 1;
      idx = 0; nb = 0; bad_seq = 0; prev = 'x;
      @(negedge clk);
      prof_sel = 2'(ps);
      @(negedge clk);
      chk(busy === 1'b1, "R9 busy after profile change", 32'(busy), 1);
      while (busy === 1'b1 && nb < 100000) begin
         if (nb == 0 || word_out !== prev) begin
            if (idx >= cnt || word_out !== tab_val(first + idx)) begin
               if (!bad_seq)
                  chk(0, "R4 word order", word_out, (idx < cnt) ? tab_val(first + idx) : 32'hFFFF_FFFF);
               bad_seq = 1;
            end
            idx++;
            prev = word_out;
         end
         nb++;
         @(negedge clk);
      end
      lo = 4 * cnt * (rate + 1) - 3;
      hi = 4 * cnt * (rate + 1);
      chk(idx == cnt, (first > last) ? "R7 single entry count" : "R4 entry count", idx, cnt);
      chk(nb >= lo && nb <= hi, "R5 busy duration", nb, hi);
      chk(done === 1'b1, "R5 done on busy fall", 32'(done), 1);
      @(negedge clk);
      chk(done === 1'b0, "R5 done one cycle", 32'(done), 0);
      chk(word_out === (nd ? IDLE : tab_val(fin)), "R6 output after sweep", word_out,
          nd ? IDLE : tab_val(fin));
   endtask

   initial begin : watchdog
      #1_900_000;
      n_total++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] held;
      process::self().srandom(32'd1234);
      #22;
      // R1 reset state
      chk(busy === 1'b0 && done === 1'b0 && bad_mode === 1'b0, "R1 flags at reset",
          {busy, done, bad_mode}, 0);
      chk(word_out === IDLE, "R1 idle word at reset", word_out, IDLE);
      @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < 1024; a++) begin
         @(negedge clk);
         ram_we = 1'b1; ram_waddr = 10'(a); ram_wdata = tab_val(a);
      end
      @(negedge clk);
      ram_we = 1'b0;

      // R2: staged write without update; live word still zero => mode 0 => bad_mode
      put_cw(1, pack_cw(0, 20, 10, 1, 0), 0);
      @(negedge clk); prof_sel = 2'b01;
      @(negedge clk); @(negedge clk);
      chk(bad_mode === 1'b1 && busy === 1'b0, "R2 staged word not live", {busy, bad_mode}, 1);
      chk(word_out === IDLE, "R2 output untouched", word_out, IDLE);
      // now update and go back to profile 0 then 1
      cw_update = 1'b1; @(negedge clk); cw_update = 1'b0;
      put_cw(0, pack_cw(0, 3, 0, 1, 0), 1);
      sweep(0, 0, 3, 0, 0);
      chk(bad_mode === 1'b0, "R8 bad_mode cleared by ramp start", 32'(bad_mode), 0);
      sweep(1, 10, 20, 0, 0);   // R2 after update, R9 00->01

      // R7 reversed addresses
      put_cw(0, pack_cw(1, 5, 40, 1, 0), 1);
      sweep(0, 40, 5, 1, 0);

      // R8 unsupported mode keeps output
      put_cw(1, pack_cw(0, 9, 2, 2, 1), 1);
      held = word_out;
      @(negedge clk); prof_sel = 2'b01;
      @(negedge clk);
      chk(bad_mode === 1'b1 && busy === 1'b0, "R8 unsupported mode flagged", {busy, bad_mode}, 1);
      repeat (12) @(negedge clk);
      chk(word_out === held, "R8 output unchanged", word_out, held);

      // R6 no-dwell and top of table, profile 3
      put_cw(3, pack_cw(2, 1023, 1020, 1, 1), 1);
      sweep(3, 1020, 1023, 2, 1);

      // random sweeps alternating profiles
      for (int t = 0; t < 30; t++) begin
         int f, l, r, p;
         bit n;
         f = int'($urandom_range(0, 1023));
         l = f + int'($urandom_range(0, 6));
         if (l > 1023) l = 1023;
         if ($urandom_range(0, 5) == 0) l = int'($urandom_range(0, 1023));
         r = int'($urandom_range(0, 3));
         n = 1'($urandom_range(0, 1));
         p = (int'(prof_sel) + 1 + int'($urandom_range(0, 2))) % 4;
         put_cw(p, pack_cw(r, l, f, 1, n), 1);
         sweep(p, f, l, r, n);
      end

      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end
endmodule